// File: doc/BRIEF.md
# Coefficient Bank Store with Integrity Checking

This block sits on the register side of a filter engine. It keeps two banks of programmable filter coefficients, a large FIR bank and a smaller IIR bank. The host reaches each bank through one byte-wide window address. Every read or write at a window moves that bank's byte pointer forward by one. An access to any other address puts the pointer back at byte zero, so a host that wants to stream a bank touches some other register once and then keeps hitting the window.

A background scanner walks the covered configuration bytes, then the FIR bank, then the IIR bank, one byte per clock, and recomputes a CRC for each of the three regions. The scanner restarts from the beginning after every write that is not a write to the error register, and after the enable input rises. When the enable input is high, a region whose recomputed CRC differs from the value the host has stored sets that region's error bit. The three error bits are combined into one global error output. The error bits do not all clear in the same way: the configuration-region bit clears through a register write, while the two bank bits clear only when the enable input is cycled.

Top module: `cb_coef_guard`

## Requirements
- R1: After reset, `rd_data` is 00h and all four error outputs are low.
- R2: Configuration bytes live at 00h, 01h and 05h–11h, and a read returns the value last written there. Addresses 02h and 04h read 00h, and writes to them are dropped. A read at address A, strobed in one cycle, shows on `rd_data` after that clock edge. `rd_data` holds its value in every cycle without a read strobe.
- R3: The FIR window at 13h holds FIR_WORDS×WORD_BYTES bytes. The IIR window at 16h holds IIR_BYTES bytes. Each read or write at a window uses the byte at that bank's pointer and then advances the pointer, which wraps to byte 0 after the last byte.
- R4: Any read or write at an address other than a bank's window returns that bank's pointer to byte 0.
- R5: A read and a write at the same window in the same cycle return the old byte, store the new byte, and advance the pointer once.
- R6: The configuration CRC is CRC-8 (polynomial 07h, initial value FFh, MSB first) over addresses 00h, 01h, 05h…11h in ascending order. It is compared with the byte at 12h. The FIR CRC is CRC-16 (polynomial 8005h, initial value FFFFh, MSB first) over the FIR bytes in pointer order. It is compared with {14h,15h}, where 14h is the high byte. The IIR CRC is CRC-8 as above over the IIR bytes and is compared with 17h. With `crc_en` high, a mismatch sets the region's error bit and a match sets nothing.
- R7: While `crc_en` is low, no error bit is set.
- R8: The error register at 03h reads {00000b, iir, fir, cfg} in bits 7..0. Writing it with bit 0 = 1 clears the configuration error. Bit 0 = 0 leaves it unchanged. A detected mismatch in the same cycle wins over the clear.
- R9: Writes to 03h do not clear the FIR and IIR error bits. They clear on the clock where `crc_en` goes from low to high. Lowering `crc_en` alone keeps them set.
- R10: `err_any` is high exactly while at least one of the three error bits is high, and it falls once all three are clear.
- R11: After the last write, the error bits reach their final value within one full scan, which is 15+FIR bytes+IIR bytes clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register address for the read and write strobes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| crc_en | input | 1 | Integrity-check enable |
| err_main | output | 1 | Configuration-region CRC error |
| err_fir | output | 1 | FIR-bank CRC error |
| err_iir | output | 1 | IIR-bank CRC error |
| err_any | output | 1 | OR of the three error bits |

## Verification
Two functions can act on one bank byte in the same clock: the read path returns the byte at the pointer while the write path replaces that byte, and both advance the same pointer. The bench puts both strobes on the FIR window in one cycle. It expects the pre-write byte on `rd_data`. It then expects the next window read to return the following byte, which shows the pointer moved only once, and a later read from byte 0 to return the new value. A reference model in the bench tracks memory and pointers and predicts `rd_data` on every clock. Error bits are judged after a full scan, and at the exact clock of each clear.

// File: rtl/cb_pkg.sv
package cb_pkg;
   // Addresses whose position the block's behaviour depends on
   localparam logic [7:0] A_STAT  = 8'h03;
   localparam logic [7:0] A_CFGHI = 8'h11;
   localparam logic [7:0] A_MCRC  = 8'h12;
   localparam logic [7:0] A_FWIN  = 8'h13;
   localparam logic [7:0] A_FCRCH = 8'h14;
   localparam logic [7:0] A_FCRCL = 8'h15;
   localparam logic [7:0] A_IWIN  = 8'h16;
   localparam logic [7:0] A_ICRC  = 8'h17;
   localparam int CFG_N   = 18;   // byte slots 00h..11h
   localparam int COVER_N = 15;   // slots that feed the configuration CRC

   // k-th covered slot: 00h, 01h, then 05h onward
   function automatic logic [4:0] cover_slot(input logic [3:0] k);
      return (k < 4'd2) ? {1'b0, k} : ({1'b0, k} + 5'd3);
   endfunction

   function automatic logic is_cfg(input logic [7:0] a);
      return (a <= A_CFGHI) && (a != 8'h02) && (a != A_STAT) && (a != 8'h04);
   endfunction
endpackage

// File: rtl/cb_crc_step.sv
module cb_crc_step #(
   parameter int             W    = 8,
   parameter logic [W-1:0]   POLY = 'h07
) (
   input  logic [W-1:0] crc_in,
   input  logic [7:0]   data,
   output logic [W-1:0] crc_out
);
   generate
      if (W < 8) begin : g_bad_width
         $error("cb_crc_step: W must be at least 8");
      end
   endgenerate

   // One byte, MSB first, eight unrolled shift steps
   always_comb begin
      logic [W-1:0] c;
      c = crc_in;
      for (int b = 7; b >= 0; b--) begin
         if (c[W-1] ^ data[b]) c = {c[W-2:0], 1'b0} ^ POLY;
         else                  c = {c[W-2:0], 1'b0};
      end
      crc_out = c;
   end
endmodule

// File: rtl/cb_bank.sv
module cb_bank #(
   parameter int          DEPTH = 512,
   parameter logic [7:0]  WIN   = 8'h13,
   localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    addr,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic          rd_en,
   output logic [7:0]    cur_byte,
   input  logic [AW-1:0] scan_idx,
   output logic [7:0]    scan_byte
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cb_bank: DEPTH must be at least 2");
      end
   endgenerate

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] ptr;
   logic          access, on_win;

   assign access = rd_en || wr_en;
   assign on_win = (addr == WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ptr <= '0;
      else if (access && on_win) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      else if (access)           ptr <= '0;
   end

   always_ff @(posedge clk) begin
      if (wr_en && on_win) mem[ptr] <= wr_data;
   end

   assign cur_byte  = mem[ptr];
   assign scan_byte = mem[scan_idx];
endmodule

// File: rtl/cb_scan.sv
module cb_scan #(
   parameter int  MAIN_N = 15,
   parameter int  FIR_N  = 512,
   parameter int  IIR_N  = 40,
   localparam int MW     = $clog2(MAIN_N),
   localparam int FW     = $clog2(FIR_N),
   localparam int IW     = $clog2(IIR_N),
   localparam int TOTAL  = MAIN_N + FIR_N + IIR_N,
   localparam int TW     = $clog2(TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          en,
   input  logic [7:0]    main_byte,
   input  logic [7:0]    fir_byte,
   input  logic [7:0]    iir_byte,
   input  logic [7:0]    ref_main,
   input  logic [15:0]   ref_fir,
   input  logic [7:0]    ref_iir,
   output logic [MW-1:0] main_sel,
   output logic [FW-1:0] fir_sel,
   output logic [IW-1:0] iir_sel,
   output logic          hit_main,
   output logic          hit_fir,
   output logic          hit_iir
);
   localparam logic [TW-1:0] F0   = TW'(MAIN_N);
   localparam logic [TW-1:0] I0   = TW'(MAIN_N + FIR_N);
   localparam logic [TW-1:0] MEND = TW'(MAIN_N - 1);
   localparam logic [TW-1:0] FEND = TW'(MAIN_N + FIR_N - 1);
   localparam logic [TW-1:0] ENDC = TW'(TOTAL - 1);

   generate
      if (MAIN_N < 2 || FIR_N < 2 || IIR_N < 2) begin : g_bad_region
         $error("cb_scan: every region needs at least two bytes");
      end
   endgenerate

   logic [TW-1:0] cnt;
   logic [7:0]    acc_m, acc_i, nxt_m, nxt_i;
   logic [15:0]   acc_f, nxt_f;
   logic          in_m, in_f, live;

   assign in_m     = cnt < F0;
   assign in_f     = !in_m && (cnt < I0);
   assign main_sel = MW'(cnt);
   assign fir_sel  = FW'(cnt - F0);
   assign iir_sel  = IW'(cnt - I0);

   cb_crc_step #(.W(8),  .POLY(8'h07))    u_step_m (.crc_in(acc_m), .data(main_byte), .crc_out(nxt_m));
   cb_crc_step #(.W(16), .POLY(16'h8005)) u_step_f (.crc_in(acc_f), .data(fir_byte),  .crc_out(nxt_f));
   cb_crc_step #(.W(8),  .POLY(8'h07))    u_step_i (.crc_in(acc_i), .data(iir_byte),  .crc_out(nxt_i));

   // A region is judged on its last byte, unless this cycle restarts the walk
   assign live     = en && !restart;
   assign hit_main = live && (cnt == MEND) && (nxt_m != ref_main);
   assign hit_fir  = live && (cnt == FEND) && (nxt_f != ref_fir);
   assign hit_iir  = live && (cnt == ENDC) && (nxt_i != ref_iir);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         acc_m <= '1;
         acc_f <= '1;
         acc_i <= '1;
      end else if (restart || cnt == ENDC) begin
         cnt   <= '0;
         acc_m <= '1;
         acc_f <= '1;
         acc_i <= '1;
      end else begin
         cnt <= cnt + 1'b1;
         if (in_m)              acc_m <= nxt_m;
         if (in_f)              acc_f <= nxt_f;
         if (!in_m && !in_f)    acc_i <= nxt_i;
      end
   end
endmodule

// File: rtl/cb_coef_guard.sv
module cb_coef_guard
   import cb_pkg::*;
#(
   parameter int  FIR_WORDS  = 128,
   parameter int  WORD_BYTES = 4,
   parameter int  IIR_BYTES  = 40,
   localparam int FIR_BYTES  = FIR_WORDS * WORD_BYTES,
   localparam int FAW        = $clog2(FIR_BYTES),
   localparam int IAW        = $clog2(IIR_BYTES)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] addr,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   input  logic       crc_en,
   output logic       err_main,
   output logic       err_fir,
   output logic       err_iir,
   output logic       err_any
);
   generate
      if (FIR_WORDS < 1 || WORD_BYTES < 1) begin : g_bad_fir
         $error("cb_coef_guard: FIR bank size must be positive");
      end
   endgenerate

   logic [7:0]     cfg [CFG_N];
   logic [7:0]     mcrc, icrc, rd_mux;
   logic [15:0]    fcrc;
   logic [7:0]     fir_cur, iir_cur, fir_scan, iir_scan;
   logic [3:0]     main_sel;
   logic [FAW-1:0] fir_sel;
   logic [IAW-1:0] iir_sel;
   logic           hit_m, hit_f, hit_i;
   logic           en_q, en_rise, restart, clr_main;

   assign en_rise  = crc_en && !en_q;
   assign restart  = (wr_en && addr != A_STAT) || en_rise;
   assign clr_main = wr_en && (addr == A_STAT) && wr_data[0];

   cb_bank #(.DEPTH(FIR_BYTES), .WIN(A_FWIN)) u_fir (
      .clk, .rst_n, .addr, .wr_en, .wr_data, .rd_en,
      .cur_byte(fir_cur), .scan_idx(fir_sel), .scan_byte(fir_scan));

   cb_bank #(.DEPTH(IIR_BYTES), .WIN(A_IWIN)) u_iir (
      .clk, .rst_n, .addr, .wr_en, .wr_data, .rd_en,
      .cur_byte(iir_cur), .scan_idx(iir_sel), .scan_byte(iir_scan));

   cb_scan #(.MAIN_N(COVER_N), .FIR_N(FIR_BYTES), .IIR_N(IIR_BYTES)) u_scan (
      .clk, .rst_n, .restart, .en(crc_en),
      .main_byte(cfg[cover_slot(main_sel)]), .fir_byte(fir_scan), .iir_byte(iir_scan),
      .ref_main(mcrc), .ref_fir(fcrc), .ref_iir(icrc),
      .main_sel, .fir_sel, .iir_sel,
      .hit_main(hit_m), .hit_fir(hit_f), .hit_iir(hit_i));

   // Configuration bytes and stored reference CRCs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < CFG_N; k++) cfg[k] <= '0;
         mcrc <= '0;
         fcrc <= '0;
         icrc <= '0;
      end else if (wr_en) begin
         if (is_cfg(addr)) cfg[addr[4:0]] <= wr_data;
         case (addr)
            A_MCRC:  mcrc       <= wr_data;
            A_FCRCH: fcrc[15:8] <= wr_data;
            A_FCRCL: fcrc[7:0]  <= wr_data;
            A_ICRC:  icrc       <= wr_data;
            default: ;
         endcase
      end
   end

   // Error bits: detection has priority over clearing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         err_main <= 1'b0;
         err_fir  <= 1'b0;
         err_iir  <= 1'b0;
      end else begin
         en_q <= crc_en;
         if (hit_m)         err_main <= 1'b1;
         else if (clr_main) err_main <= 1'b0;
         if (hit_f)         err_fir  <= 1'b1;
         else if (en_rise)  err_fir  <= 1'b0;
         if (hit_i)         err_iir  <= 1'b1;
         else if (en_rise)  err_iir  <= 1'b0;
      end
   end

   assign err_any = err_main | err_fir | err_iir;

   always_comb begin
      rd_mux = 8'h00;
      if (is_cfg(addr)) rd_mux = cfg[addr[4:0]];
      else begin
         case (addr)
            A_STAT:  rd_mux = {5'b0, err_iir, err_fir, err_main};
            A_MCRC:  rd_mux = mcrc;
            A_FWIN:  rd_mux = fir_cur;
            A_FCRCH: rd_mux = fcrc[15:8];
            A_FCRCL: rd_mux = fcrc[7:0];
            A_IWIN:  rd_mux = iir_cur;
            A_ICRC:  rd_mux = icrc;
            default: rd_mux = 8'h00;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= 8'h00;
      else if (rd_en) rd_data <= rd_mux;
   end
endmodule

// File: rtl/cb_coef_guard_chk.sv
module cb_coef_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] addr,
   input logic       wr_en,
   input logic       wr_lsb,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input logic       crc_en,
   input logic       err_main,
   input logic       err_fir,
   input logic       err_iir,
   input logic       err_any
);
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rd_data)); // R2
   AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) ($rose(err_main) || $rose(err_fir) || $rose(err_iir)) |-> $past(crc_en)); // R7
   AST_MAIN_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_main) |-> $past(wr_en && addr == 8'h03 && wr_lsb)); // R8
   AST_FIR_CLR_BY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_fir) |-> ($past(crc_en) && !$past(crc_en, 2))); // R9
   AST_IIR_CLR_BY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_iir) |-> ($past(crc_en) && !$past(crc_en, 2))); // R9
   AST_ANY_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_any) |-> !(err_main || err_fir || err_iir)); // R10
   AST_ANY_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_any) |-> (err_main || err_fir || err_iir)); // R10
endmodule

bind cb_coef_guard cb_coef_guard_chk u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_lsb(wr_data[0]),
   .rd_en(rd_en), .rd_data(rd_data), .crc_en(crc_en),
   .err_main(err_main), .err_fir(err_fir), .err_iir(err_iir), .err_any(err_any));

// File: tb/sim_cb_coef_guard.sv
`timescale 1ns/1ps
module sim_cb_coef_guard;
   localparam int FIR_BYTES = 512;
   localparam int IIR_BYTES = 40;
   localparam int SWEEP     = 15 + FIR_BYTES + IIR_BYTES;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic       crc_en = 1'b0;
   logic [7:0] rd_data;
   logic       err_main, err_fir, err_iir, err_any;

   always #2 clk = ~clk;

   cb_coef_guard u0 (
      .clk, .rst_n, .addr, .wr_en, .wr_data, .rd_en, .rd_data,
      .crc_en, .err_main, .err_fir, .err_iir, .err_any);

   int checks = 0;
   int errors = 0;
   bit live = 0;
   bit done = 0;
   string cur_tag = "R2";

   // Reference model state
   int   mcfg [18];
   int   fir_m [FIR_BYTES];
   int   iir_m [IIR_BYTES];
   int   fp = 0, ip = 0;
   int   mc = 0, fc = 0, ic = 0;
   logic [7:0] exp_rd = 8'h00;
   bit   exp_main = 0, exp_fir = 0, exp_iir = 0, en_prev = 0;

   function automatic bit cfg_addr(int a);
      return a <= 17 && a != 2 && a != 3 && a != 4;
   endfunction

   function automatic int crc_upd(int crc, int w, int poly, int b);
      for (int i = 7; i >= 0; i--) begin
         int top = (crc >> (w - 1)) & 1;
         int din = (b >> i) & 1;
         crc = (crc << 1) & ((1 << w) - 1);
         if ((top ^ din) != 0) crc = crc ^ poly;
      end
      return crc;
   endfunction

   function automatic int main_crc();
      int c = 255;
      for (int k = 0; k < 18; k++) if (cfg_addr(k)) c = crc_upd(c, 8, 7, mcfg[k]);
      return c;
   endfunction

   function automatic int fir_crc();
      int c = 65535;
      for (int k = 0; k < FIR_BYTES; k++) c = crc_upd(c, 16, 32773, fir_m[k]);
      return c;
   endfunction

   function automatic int iir_crc();
      int c = 255;
      for (int k = 0; k < IIR_BYTES; k++) c = crc_upd(c, 8, 7, iir_m[k]);
      return c;
   endfunction

   function automatic int mread(int a);
      if (cfg_addr(a)) return mcfg[a];
      case (a)
         3:  return (int'(exp_iir) << 2) | (int'(exp_fir) << 1) | int'(exp_main);
         18: return mc;
         19: return fir_m[fp];
         20: return (fc >> 8) & 255;
         21: return fc & 255;
         22: return iir_m[ip];
         23: return ic;
         default: return 0;
      endcase
   endfunction

   task automatic model(int a, bit w, int d, bit r);
      if (r) exp_rd = 8'(mread(a));
      if (w) begin
         if (cfg_addr(a)) mcfg[a] = d;
         case (a)
            3:  if ((d & 1) != 0) exp_main = 0;
            18: mc = d;
            19: fir_m[fp] = d;
            20: fc = (fc & 255) | (d << 8);
            21: fc = (fc & 65280) | d;
            22: iir_m[ip] = d;
            23: ic = d;
            default: ;
         endcase
      end
      if (r || w) begin
         fp = (a == 19) ? (fp + 1) % FIR_BYTES : 0;
         ip = (a == 22) ? (ip + 1) % IIR_BYTES : 0;
      end
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_flags(string tag);
      chk({tag, " err_main"}, int'(err_main), int'(exp_main));
      chk({tag, " err_fir"},  int'(err_fir),  int'(exp_fir));
      chk({tag, " err_iir"},  int'(err_iir),  int'(exp_iir));
      chk({tag, " err_any R10"}, int'(err_any), int'(exp_main | exp_fir | exp_iir));
   endtask

   // One bus cycle: driven at a falling edge, modelled at the rising edge
   task automatic bus(int a, bit w, int d, bit r);
      addr = 8'(a); wr_en = w; wr_data = 8'(d); rd_en = r;
      @(posedge clk);
      model(a, w, d, r);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic set_en(bit v);
      crc_en = v;
      @(posedge clk);
      if (v && !en_prev) begin exp_fir = 0; exp_iir = 0; end
      en_prev = v;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (SWEEP + 8) @(negedge clk);
      if (crc_en) begin
         if (main_crc() != mc) exp_main = 1;
         if (fir_crc() != fc)  exp_fir = 1;
         if (iir_crc() != ic)  exp_iir = 1;
      end
   endtask

   task automatic put_crcs();
      bus(18, 1, main_crc(), 0);
      bus(20, 1, (fir_crc() >> 8) & 255, 0);
      bus(21, 1, fir_crc() & 255, 0);
      bus(23, 1, iir_crc(), 0);
   endtask

   task automatic wrap_up();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Read data is compared against the model on every clock
   always @(negedge clk) begin
      if (live && rst_n) chk({cur_tag, " rd_data"}, int'(rd_data), int'(exp_rd));
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired, actual running expected finished");
         wrap_up();
      end
   end

   initial begin
      int keep;
      for (int k = 0; k < 18; k++) mcfg[k] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 rd_data", int'(rd_data), 0);
      exp_main = 0; exp_fir = 0; exp_iir = 0;
      chk_flags("R1");
      live = 1;

      // R2: configuration storage and reserved bytes
      cur_tag = "R2";
      for (int a = 0; a < 18; a++) bus(a, 1, (a * 7 + 3) & 255, 0);
      for (int a = 0; a < 18; a++) bus(a, 0, 0, 1);
      bus(2, 1, 255, 0); bus(2, 0, 0, 1);
      bus(4, 1, 255, 0); bus(4, 0, 0, 1);

      // R3: fill both banks through their windows
      cur_tag = "R3";
      bus(0, 0, 0, 1);
      for (int i = 0; i < FIR_BYTES; i++) bus(19, 1, (i * 13 + 5) & 255, 0);
      bus(0, 0, 0, 1);
      for (int i = 0; i < IIR_BYTES; i++) bus(22, 1, (i * 29 + 1) & 255, 0);
      bus(0, 0, 0, 1);
      for (int i = 0; i < 5; i++) bus(19, 0, 0, 1);
      // R4: another address puts the pointer back at byte 0
      cur_tag = "R4";
      bus(1, 0, 0, 1);
      bus(19, 0, 0, 1);
      chk("R4 fir byte0 after other access", int'(rd_data), 5);
      // R3: full pass plus one read shows the wrap
      cur_tag = "R3";
      bus(0, 0, 0, 1);
      for (int i = 0; i <= FIR_BYTES; i++) bus(19, 0, 0, 1);
      chk("R3 fir wrap to byte0", int'(rd_data), 5);
      cur_tag = "R4";
      bus(22, 0, 0, 1); bus(22, 0, 0, 1); bus(22, 0, 0, 1);
      bus(19, 0, 0, 1);
      bus(22, 0, 0, 1);
      chk("R4 iir byte0 after other access", int'(rd_data), 1);

      // R6: matching CRCs give no error
      cur_tag = "R6";
      put_crcs();
      set_en(1);
      settle();
      chk_flags("R6 match");

      // R7: disabled check never flags
      cur_tag = "R7";
      set_en(0);
      bus(18, 1, mc ^ 255, 0);
      settle();
      chk_flags("R7 disabled");
      bus(18, 1, main_crc(), 0);
      set_en(1);
      settle();
      chk_flags("R7 re-enabled");

      // R6/R8: configuration mismatch, sticky bit, clear rules
      cur_tag = "R8";
      bus(18, 1, main_crc() ^ 8'h5A, 0);
      settle();
      chk_flags("R6 cfg mismatch");
      bus(3, 0, 0, 1);
      bus(3, 1, 0, 0);
      chk_flags("R8 bit0 zero ignored");
      bus(3, 1, 6, 0);
      chk_flags("R8 other bits ignored");
      bus(18, 1, main_crc(), 0);
      settle();
      chk_flags("R8 sticky after fix");
      bus(3, 1, 1, 0);
      chk_flags("R8 cleared by write");
      settle();
      chk_flags("R11 stays clear");

      // R9: FIR bank mismatch
      cur_tag = "R9";
      keep = fir_m[0];
      bus(0, 0, 0, 1);
      bus(19, 1, keep ^ 255, 0);
      settle();
      chk_flags("R6 fir mismatch");
      bus(0, 0, 0, 1);
      bus(19, 1, keep, 0);
      settle();
      chk_flags("R9 sticky after fix");
      bus(3, 1, 255, 0);
      chk_flags("R9 status write no clear");
      set_en(0);
      chk_flags("R9 enable low keeps");
      set_en(1);
      chk_flags("R9 enable rise clears");
      settle();
      chk_flags("R11 fir stays clear");

      // R10: two bits set, one cleared, global flag remains
      cur_tag = "R10";
      bus(23, 1, ic ^ 8'h33, 0);
      bus(18, 1, mc ^ 8'h81, 0);
      settle();
      chk_flags("R10 cfg and iir set");
      bus(18, 1, main_crc(), 0);
      bus(3, 1, 1, 0);
      chk_flags("R10 iir keeps global");
      bus(23, 1, iir_crc(), 0);
      settle();
      set_en(0);
      set_en(1);
      chk_flags("R10 global clears");

      // R5: read and write at one window in one cycle
      cur_tag = "R5";
      bus(0, 0, 0, 1);
      keep = fir_m[0];
      bus(19, 1, 165, 1);
      chk("R5 old byte returned", int'(rd_data), keep);
      bus(19, 0, 0, 1);
      chk("R5 single advance", int'(rd_data), (1 * 13 + 5) & 255);
      bus(0, 0, 0, 1);
      bus(19, 0, 0, 1);
      chk("R5 new byte stored", int'(rd_data), 165);

      live = 0;
      done = 1;
      wrap_up();
   end
endmodule